// File: doc/BRIEF.md
# Half-Step Pre-Divider with M/N Fractional Rate Stage

This block turns a stream of source ticks into a slower stream of output ticks. Each input tick on `tick_i` marks one half-period of the source clock. The output is a clock-enable pulse train, not a real clock.

The first stage is a pre-divider that counts half-periods. It can therefore divide by integer and half-integer ratios. The second stage is an optional M/N accumulator that scales the rate by m/n. Its average output rate is source × 2/(h+1) × m/n. A level output gives a duty-shaped waveform taken from the accumulator phase.

The settings are written in their encoded register form. These are the pre-divider field h, the numerator m, the complemented N field, the complemented D field and a mode. A single `load_i` strobe captures all of them at once and restarts both counters from a clean phase.

Top module: `frac_clk_div`

## Requirements
- R1: With h = 0 the pre-divider behaves as a pass-through of the source. One pre-divided tick is produced for every two input half-period ticks. h = 1 gives the same ratio.
- R2: With h > 0, one pre-divided tick is produced for every h+1 input ticks. Odd values of h+1 therefore give half-integer ratios, for example h = 2 gives ratio 1.5.
- R3: With mode = 0 the M/N stage is bypassed and every pre-divided tick appears on `tick_o`.
- R4: With mode ≠ 0 the effective n is decoded as (bitwise NOT of the N field + m), taken modulo 2^MW. After P pre-divided ticks from a load, `tick_o` has pulsed floor(P·m/n) times.
- R5: The accumulator adds m on each pre-divided tick. When the sum reaches n it subtracts n and emits one output tick. It changes only on pre-divided ticks, so sparse input ticks give the same count as dense ones.
- R6: `level_o` is high only when the mode is nonzero, no error is flagged, and the accumulator is below the duty threshold. The duty threshold is the bitwise NOT of the D field, masked to MW bits. `level_o` is low in mode 0.
- R7: `load_i` captures all settings and clears the pre-divider counter and the accumulator. An input tick in the load cycle produces no output and is not counted.
- R8: With mode ≠ 0, if the decoded n is 0 or m > n, then `err_o` is high and `tick_o` and `level_o` are held low. A later load of valid settings clears the error.
- R9: After reset the captured settings are all zero (mode 0, h 0), and `tick_o`, `level_o` and `err_o` are low.
- R10: `tick_o` is never high in a cycle where `tick_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Source half-period tick |
| load_i | input | 1 | Capture settings and restart counters |
| hdiv_i | input | HW | Pre-divider field h |
| m_i | input | MW | Numerator m |
| nreg_i | input | MW | N field, holds NOT(n − m) |
| dreg_i | input | MW | D field, holds NOT(duty threshold) |
| mode_i | input | 2 | 0 = bypass M/N stage, nonzero = M/N active |
| tick_o | output | 1 | Output enable pulse |
| level_o | output | 1 | Duty-shaped level |
| err_o | output | 1 | Invalid M/N settings captured |

## Verification
A load strobe and a source tick can arrive in the same cycle. This can happen just as the pre-divider counter reaches its last count, or while the accumulator holds a nonzero phase. The bench provokes both cases. It advances the counters part-way, then asserts `load_i` together with `tick_i`. It then judges the outcome by three things: `tick_o` must stay low in that cycle, the next output must follow a full fresh period, and an accumulator phase left behind must not shorten the first M/N period.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_MN_A   = 2'd1,
    MODE_MN_B   = 2'd2,
    MODE_MN_C   = 2'd3
  } fdiv_mode_e;

  function automatic logic mode_active(fdiv_mode_e m);
    return m != MODE_BYPASS;
  endfunction
endpackage

// File: rtl/fdiv_prediv.sv
module fdiv_prediv #(
  parameter int HW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [HW-1:0] h_i,
  output logic          pre_tick_o
);
  localparam int CW = HW + 1;

  logic [CW-1:0] cnt_q, div;
  logic          last;

  // h = 0 counts as two half-periods (pass-through)
  assign div        = (h_i == '0) ? CW'(2) : (CW'(h_i) + CW'(1));
  assign last       = (cnt_q == div - CW'(1));
  assign pre_tick_o = tick_i & ~clr_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + CW'(1);
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div);
  // R1
  wrap_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_o |=> cnt_q == '0);
endmodule

// File: rtl/fdiv_mnd.sv
module fdiv_mnd #(
  parameter int MW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          step_i,
  input  logic [MW-1:0] m_i,
  input  logic [MW-1:0] n_i,
  input  logic [MW-1:0] d_i,
  output logic          fire_o,
  output logic          below_o
);
  logic [MW-1:0] acc_q;
  logic [MW:0]   sum;
  logic          ge;

  assign sum     = {1'b0, acc_q} + {1'b0, m_i};
  assign ge      = sum >= {1'b0, n_i};
  assign fire_o  = step_i & en_i & ge;
  assign below_o = acc_q < d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              acc_q <= '0;
    else if (clr_i)           acc_q <= '0;
    else if (step_i && en_i)  acc_q <= ge ? MW'(sum - {1'b0, n_i}) : sum[MW-1:0];
  end

  // R5
  acc_below_n_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> acc_q < n_i);
  // R5
  fire_needs_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> step_i);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fdiv_pkg::*;
#(
  parameter int HW = 5,
  parameter int MW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [HW-1:0] hdiv_i,
  input  logic [MW-1:0] m_i,
  input  logic [MW-1:0] nreg_i,
  input  logic [MW-1:0] dreg_i,
  input  logic [1:0]    mode_i,
  output logic          tick_o,
  output logic          level_o,
  output logic          err_o
);
  logic [HW-1:0] h_q;
  logic [MW-1:0] m_q, nreg_q, dreg_q;
  fdiv_mode_e    mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q    <= '0;
      m_q    <= '0;
      nreg_q <= '0;
      dreg_q <= '0;
      mode_q <= MODE_BYPASS;
    end else if (load_i) begin
      h_q    <= hdiv_i;
      m_q    <= m_i;
      nreg_q <= nreg_i;
      dreg_q <= dreg_i;
      mode_q <= fdiv_mode_e'(mode_i);
    end
  end

  logic [MW-1:0] n_dec, d_thr;
  logic          active, bad, en;
  logic          pre_tick, fire, below;

  assign n_dec  = (~nreg_q) + m_q;
  assign d_thr  = ~dreg_q;
  assign active = mode_active(mode_q);
  assign bad    = active & ((n_dec == '0) | (m_q > n_dec));
  assign en     = active & ~bad;

  fdiv_prediv #(.HW(HW)) u_prediv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load_i),
    .tick_i    (tick_i),
    .h_i       (h_q),
    .pre_tick_o(pre_tick)
  );

  fdiv_mnd #(.MW(MW)) u_mnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .en_i   (en),
    .step_i (pre_tick),
    .m_i    (m_q),
    .n_i    (n_dec),
    .d_i    (d_thr),
    .fire_o (fire),
    .below_o(below)
  );

  assign tick_o  = active ? fire : pre_tick;
  assign level_o = en & below;
  assign err_o   = bad;

  // R10
  tick_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
  // R8
  err_mutes_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !tick_o && !level_o);
  // R7
  load_mutes_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !tick_o);
endmodule

// File: tb/tb_frac_clk_div.sv
module tb_frac_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, load = 1'b0;
  logic [4:0] hdiv = '0;
  logic [7:0] m = '0, nreg = '0, dreg = '0;
  logic [1:0] mode = '0;
  logic       tick_o, level_o, err_o;

  int checks = 0, fails = 0;
  logic t_s, l_s, e_s;
  bit done = 0;

  always #10 clk = ~clk;

  frac_clk_div dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_i(load),
    .hdiv_i(hdiv), .m_i(m), .nreg_i(nreg), .dreg_i(dreg), .mode_i(mode),
    .tick_o(tick_o), .level_o(level_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [4:0]  h;
    logic [7:0]  m;
    logic [7:0]  nr;
    logic [1:0]  md;
    logic [15:0] t;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC[9] = '{
    '{5'd0, 8'd0, 8'h00, 2'd0, 16'd20, 16'd10},
    '{5'd2, 8'd0, 8'h00, 2'd0, 16'd30, 16'd10},
    '{5'd4, 8'd0, 8'h00, 2'd0, 16'd25, 16'd5},
    '{5'd1, 8'd0, 8'h00, 2'd0, 16'd20, 16'd10},
    '{5'd0, 8'd1, 8'hFD, 2'd2, 16'd60, 16'd10},
    '{5'd2, 8'd2, 8'hFC, 2'd2, 16'd45, 16'd6},
    '{5'd0, 8'd3, 8'hFA, 2'd1, 16'd34, 16'd6},
    '{5'd0, 8'd0, 8'hFB, 2'd2, 16'd20, 16'd0},
    '{5'd0, 8'd5, 8'hFF, 2'd3, 16'd20, 16'd10}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample combinational outputs shortly after
  task automatic step(input logic tk, input logic ld);
    @(negedge clk);
    tick = tk;
    load = ld;
    #1;
    t_s = tick_o;
    l_s = level_o;
    e_s = err_o;
    @(posedge clk);
  endtask

  task automatic cfg(input logic [4:0] h, input logic [7:0] mm, input logic [7:0] nr,
                     input logic [7:0] dr, input logic [1:0] md);
    hdiv = h; m = mm; nreg = nr; dreg = dr; mode = md;
    step(1'b0, 1'b1);
  endtask

  task automatic run(input int n, input int gap, output int cnt, output int bad_src);
    cnt = 0;
    bad_src = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      cnt += int'(t_s);
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0);
        if (t_s) bad_src++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt, bs;
    string req;
    #1;
    @(negedge clk);
    #1;
    // R9 reset state
    check("R9 tick_o", int'(tick_o), 0);
    check("R9 level_o", int'(level_o), 0);
    check("R9 err_o", int'(err_o), 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R9: defaults act as h=0 pass-through
    run(10, 0, cnt, bs);
    check("R9 default ratio", cnt, 5);

    // table walk
    for (int k = 0; k < 9; k++) begin
      cfg(VEC[k].h, VEC[k].m, VEC[k].nr, 8'hFF, VEC[k].md);
      run(int'(VEC[k].t), 0, cnt, bs);
      if (VEC[k].md != 0) req = "R4 mn";
      else if (VEC[k].h <= 1) req = "R1 R3 pass";
      else req = "R2 halfstep";
      check(req, cnt, int'(VEC[k].exp));
    end

    // R5 sparse ticks: m=1 n=3, 12 ticks with gaps
    cfg(5'd0, 8'd1, 8'hFD, 8'hFF, 2'd2);
    run(12, 1, cnt, bs);
    check("R5 sparse count", cnt, 2);
    // R10 no output without source tick
    check("R10 idle tick_o", bs, 0);

    // R6 duty: m=1 n=4 d=2 -> acc 0,1,2,3,0
    cfg(5'd0, 8'd1, 8'hFC, 8'hFD, 2'd2);
    step(1'b0, 1'b0);
    check("R6 level acc0", int'(l_s), 1);
    run(2, 0, cnt, bs); step(1'b0, 1'b0);
    check("R6 level acc1", int'(l_s), 1);
    run(2, 0, cnt, bs); step(1'b0, 1'b0);
    check("R6 level acc2", int'(l_s), 0);
    run(2, 0, cnt, bs); step(1'b0, 1'b0);
    check("R6 level acc3", int'(l_s), 0);
    run(2, 0, cnt, bs); step(1'b0, 1'b0);
    check("R6 level wrap", int'(l_s), 1);
    cfg(5'd0, 8'd1, 8'hFC, 8'hFD, 2'd0);
    step(1'b0, 1'b0);
    check("R6 level mode0", int'(l_s), 0);

    // R7 load colliding with a tick at end of pre-divider period
    cfg(5'd0, 8'd0, 8'h00, 8'hFF, 2'd0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R7 load cycle tick_o", int'(t_s), 0);
    step(1'b1, 1'b0);
    check("R7 first after load", int'(t_s), 0);
    step(1'b1, 1'b0);
    check("R7 second after load", int'(t_s), 1);

    // R7 accumulator cleared: m=1 n=3, leave acc=2, reload with tick
    cfg(5'd0, 8'd1, 8'hFD, 8'hFF, 2'd2);
    run(4, 0, cnt, bs);
    step(1'b1, 1'b1);
    check("R7 collide tick_o", int'(t_s), 0);
    run(4, 0, cnt, bs);
    check("R7 acc cleared", cnt, 0);
    run(2, 0, cnt, bs);
    check("R7 fresh period", cnt, 1);

    // R8 n decodes to 0
    cfg(5'd0, 8'd0, 8'hFF, 8'h00, 2'd2);
    run(10, 0, cnt, bs);
    check("R8 err n0", int'(e_s), 1);
    check("R8 muted n0", cnt, 0);
    check("R8 level n0", int'(l_s), 0);
    // R8 m > n: m=200, n=(100+200) mod 256 = 44
    cfg(5'd0, 8'd200, 8'h9B, 8'h00, 2'd1);
    run(10, 0, cnt, bs);
    check("R8 err m>n", int'(e_s), 1);
    check("R8 muted m>n", cnt, 0);
    // R8 recovery
    cfg(5'd0, 8'd1, 8'hFD, 8'hFF, 2'd2);
    run(6, 0, cnt, bs);
    check("R8 err cleared", int'(e_s), 0);
    check("R8 recovered count", cnt, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule